// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM of the Microwire kind. The host places a word address on `addr_i` and a half-period length on `half_i`, then pulses `start_i` for one cycle. The block then runs a complete read transaction on its own. It opens the device with a fixed select sequence and sends an 11-bit read command, most significant bit first. It clocks in sixteen data bits and closes the device with a fixed release sequence. At the end it gives the word on `data_o` together with a one-cycle `done_o`.

Every serial step lasts one half-period, and each half-period is a whole number of system clocks. The serial clock idles high. A protect-enable line is held low for as long as the device is selected and is high at all other times. Every pin toward the device comes straight from a flip-flop, so the pins cannot glitch. The address field of the command is eight bits wide. `ADDR_W` may be any value up to eight, and narrower addresses are zero-extended into that field.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Out of reset and while idle, `cs_o`=0, `sk_o`=1, `prot_o`=1, `dout_o`=0, `busy_o`=0 and `done_o`=0.
- R2: An accepted start first drives `dout_o`, `sk_o` and `prot_o` low with `cs_o` low for one half-period. Next `cs_o` rises for one half-period with `sk_o` still low. Then `sk_o` rises for one half-period.
- R3: The command is bits 15 down to 5 of the word 0xC000 OR (address shifted left by 5). That is a 1, then 1, then 0, then the 8-bit zero-extended address, MSB first.
- R4: Each command bit is placed on `dout_o` as `sk_o` falls. `sk_o` stays low for one half-period, then high for one half-period, with `dout_o` unchanged over both halves.
- R5: From the falling `sk_o` edge that follows the last command bit until the end of the transaction, `dout_o` is 0.
- R6: Sixteen data bits are read, MSB first. Each bit has one low and one high half-period of `sk_o`, and `din_i` is sampled at the last system clock of the high half. The word assembled this way appears on `data_o` when `done_o` is high.
- R7: The release sequence is, one half-period each: `sk_o` low with `cs_o` high, then `cs_o` low, then `prot_o` high. After that `sk_o` returns high.
- R8: `done_o` is high for exactly one cycle, the same cycle in which `sk_o` returns high. The block is idle again in that cycle.
- R9: `half_i` is captured at the accepted start. A value of 0 acts as 1. Every step lasts exactly that many clocks, so `done_o` comes 60*H+1 cycles after the start edge, counting the first cycle after it as cycle 1.
- R10: `start_i`, `addr_i` and `half_i` have no effect while `busy_o` is high. The running transaction keeps its address and timing.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle before `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read; taken only when idle |
| addr_i | input | ADDR_W | Word address to read |
| half_i | input | DIV_W | Half-period of the serial clock in system clocks (0 acts as 1) |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle pulse: `data_o` holds the new word |
| data_o | output | 16 | Word read from the device |
| cs_o | output | 1 | Device select, active high |
| sk_o | output | 1 | Serial clock, idles high |
| prot_o | output | 1 | Protect-enable, low while the device is selected |
| dout_o | output | 1 | Serial data toward the device |
| din_i | input | 1 | Serial data from the device |

## Verification
The bench runs reads at the lowest and highest addresses and at the alternating patterns 0x55 and 0x2A, so the command bits take both levels in every address position. A wrong shift amount or a reversed bit order shows up as a different command at the responder. Half-periods of 0, 1, 2, 3 and 5 separate a correct divider from one that is off by one or that ignores the clamp, because the number of cycles from start to done changes with each error. One read gets a second start, a new address and a new half-period in the middle of the transfer, which shows whether the running transaction is protected from changes on its inputs.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int unsigned MW_WORD_W     = 16;
    localparam int unsigned MW_CMD_BITS   = 11;
    localparam int unsigned MW_ADDR_FIELD = MW_CMD_BITS - 3;
    localparam int unsigned MW_ADDR_SHIFT = MW_WORD_W - MW_CMD_BITS;
    localparam logic [MW_WORD_W-1:0] MW_READ_OP = 16'hC000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_CS_UP,
        ST_CLK_UP,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_EX_CLK,
        ST_EX_CS,
        ST_EX_PROT
    } mw_state_e;

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = reload_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == '0);

    // R9
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q <= $past(cnt_q)));

    // R9
    count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              next_o
);

    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = word_i;
        end else if (shift_i) begin
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign msb_o  = sh_q[WORD_W-1];
    assign next_o = sh_q[WORD_W-2];

    // R3
    cmd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (msb_o == $past(next_o)));

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clear_i) begin
            rx_d = '0;
        end else if (shift_i) begin
            rx_d = {rx_q[WORD_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_o = rx_q;

    // R6
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i) |=> (word_o[0] == $past(bit_i)));

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_eeprom_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  half_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       data_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              prot_o,
    output logic              dout_o,
    input  logic              din_i
);

    localparam int unsigned CNT_W   = $clog2(MW_WORD_W);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(MW_CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_RD  = CNT_W'(MW_WORD_W - 1);

    typedef struct packed {
        mw_state_e        state;
        logic [CNT_W-1:0] bitcnt;
        logic [DIV_W-1:0] half_m1;
        logic             cs;
        logic             sk;
        logic             prot;
        logic             dout;
        logic             done;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        state:   ST_IDLE,
        bitcnt:  '0,
        half_m1: '0,
        cs:      1'b0,
        sk:      1'b1,
        prot:    1'b1,
        dout:    1'b0,
        done:    1'b0
    };

    regs_t r_d, r_q;

    logic                 tmr_load, tmr_expire;
    logic                 cmd_load, cmd_shift, cmd_msb, cmd_next;
    logic                 rx_clear, rx_shift;
    logic [MW_WORD_W-1:0] cmd_word;
    logic                 step;

    assign cmd_word = MW_READ_OP | (MW_WORD_W'(addr_i) << MW_ADDR_SHIFT);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cmd_load  = 1'b0;
        cmd_shift = 1'b0;
        rx_clear  = 1'b0;
        rx_shift  = 1'b0;
        step      = tmr_expire && (r_q.state != ST_IDLE);

        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_ENTRY;
                    r_d.half_m1 = (half_i == '0) ? '0 : (half_i - DIV_W'(1));
                    r_d.bitcnt  = '0;
                    r_d.cs      = 1'b0;
                    r_d.sk      = 1'b0;
                    r_d.prot    = 1'b0;
                    r_d.dout    = 1'b0;
                    cmd_load    = 1'b1;
                    rx_clear    = 1'b1;
                end
            end
            ST_ENTRY: begin
                if (step) begin
                    r_d.state = ST_CS_UP;
                    r_d.cs    = 1'b1;
                end
            end
            ST_CS_UP: begin
                if (step) begin
                    r_d.state = ST_CLK_UP;
                    r_d.sk    = 1'b1;
                end
            end
            ST_CLK_UP: begin
                if (step) begin
                    r_d.state  = ST_CMD_LO;
                    r_d.sk     = 1'b0;
                    r_d.dout   = cmd_msb;
                    r_d.bitcnt = '0;
                end
            end
            ST_CMD_LO: begin
                if (step) begin
                    r_d.state = ST_CMD_HI;
                    r_d.sk    = 1'b1;
                end
            end
            ST_CMD_HI: begin
                if (step) begin
                    cmd_shift = 1'b1;
                    r_d.sk    = 1'b0;
                    if (r_q.bitcnt == LAST_CMD) begin
                        r_d.state  = ST_RD_LO;
                        r_d.dout   = 1'b0;
                        r_d.bitcnt = '0;
                    end else begin
                        r_d.state  = ST_CMD_LO;
                        r_d.dout   = cmd_next;
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                    end
                end
            end
            ST_RD_LO: begin
                if (step) begin
                    r_d.state = ST_RD_HI;
                    r_d.sk    = 1'b1;
                end
            end
            ST_RD_HI: begin
                if (step) begin
                    rx_shift = 1'b1;
                    r_d.sk   = 1'b0;
                    if (r_q.bitcnt == LAST_RD) begin
                        r_d.state = ST_EX_CLK;
                    end else begin
                        r_d.state  = ST_RD_LO;
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                    end
                end
            end
            ST_EX_CLK: begin
                if (step) begin
                    r_d.state = ST_EX_CS;
                    r_d.cs    = 1'b0;
                end
            end
            ST_EX_CS: begin
                if (step) begin
                    r_d.state = ST_EX_PROT;
                    r_d.prot  = 1'b1;
                end
            end
            ST_EX_PROT: begin
                if (step) begin
                    r_d.state = ST_IDLE;
                    r_d.sk    = 1'b1;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d = REGS_RESET;
            end
        endcase

        tmr_load = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    mw_half_timer #(
        .CNT_W (DIV_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .reload_i (r_d.half_m1),
        .expire_o (tmr_expire)
    );

    mw_cmd_shift #(
        .WORD_W (MW_WORD_W)
    ) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cmd_load),
        .word_i  (cmd_word),
        .shift_i (cmd_shift),
        .msb_o   (cmd_msb),
        .next_o  (cmd_next)
    );

    mw_rx_shift #(
        .WORD_W (MW_WORD_W)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rx_clear),
        .shift_i (rx_shift),
        .bit_i   (din_i),
        .word_o  (data_o)
    );

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign cs_o   = r_q.cs;
    assign sk_o   = r_q.sk;
    assign prot_o = r_q.prot;
    assign dout_o = r_q.dout;

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(r_q.half_m1));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && sk_o && !cs_o));

    // R2
    select_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> (!sk_o && !prot_o && !dout_o));

    // R7
    protect_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_o) |-> (!cs_o && !sk_o));

    // R5
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state inside {ST_RD_LO, ST_RD_HI, ST_EX_CLK, ST_EX_CS, ST_EX_PROT}) |-> !dout_o);

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && $rose(sk_o)) |-> $stable(dout_o));

endmodule

// File: tb/test_mw_eeprom_reader.sv
module test_mw_eeprom_reader;

    localparam int ADDR_W = 7;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DIV_W-1:0]  half_i = '0;
    logic              busy_o, done_o, cs_o, sk_o, prot_o, dout_o;
    logic [15:0]       data_o;
    logic              din_i;

    always #2.5 clk = ~clk;

    mw_eeprom_reader #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_mw_eeprom_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .half_i(half_i), .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
        .cs_o(cs_o), .sk_o(sk_o), .prot_o(prot_o), .dout_o(dout_o), .din_i(din_i)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    logic [5:0]        exp_q[$];
    string             tag_q[$];
    logic [15:0]       exp_data = '0;
    logic [ADDR_W-1:0] cur_addr = '0;

    localparam logic [5:0] IDLE_V = 6'b011000; // {cs,sk,prot,dout,done,busy}

    function automatic logic [15:0] memval(input int a);
        return 16'((a * 40503 + 4660) ^ (a << 9));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] got,
                         input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s got %h exp %h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic push_n(input logic [5:0] v, input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    // one system clock: sample away from the edge and compare with the model
    task automatic cycle();
        logic [5:0] got, e;
        string t;
        @(negedge clk);
        got = {cs_o, sk_o, prot_o, dout_o, done_o, busy_o};
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = IDLE_V;
            t = "R1";
        end
        check(got == e, t, 16'(got), 16'(e));
        if (e[1]) check(data_o == exp_data, "R6", data_o, exp_data);
    endtask

    // behavioural model of one transaction
    task automatic model_xfer(input logic [ADDR_W-1:0] a, input int h);
        int eh;
        logic [10:0] cmd;
        eh  = (h == 0) ? 1 : h;
        cmd = {3'b110, 8'(a)};
        push_n(6'b000001, "R2", eh);
        push_n(6'b100001, "R2", eh);
        push_n(6'b110001, "R2", eh);
        for (int i = 10; i >= 0; i--) begin
            push_n({3'b100, cmd[i], 2'b01}, "R4", eh);
            push_n({3'b110, cmd[i], 2'b01}, "R4", eh);
        end
        for (int i = 0; i < 16; i++) begin
            push_n(6'b100001, "R5", eh);
            push_n(6'b110001, "R5", eh);
        end
        push_n(6'b100001, "R7", eh);
        push_n(6'b000001, "R7", eh);
        push_n(6'b001001, "R7", eh);
        push_n(6'b011010, "R8", 1);
    endtask

    task automatic run_xfer(input logic [ADDR_W-1:0] a, input int h, input bit inject);
        int n;
        int eh;
        bit seen;
        eh = (h == 0) ? 1 : h;
        exp_data = memval(int'(a));
        cur_addr = a;
        model_xfer(a, h);
        addr_i  = a;
        half_i  = DIV_W'(h);
        start_i = 1'b1;
        cycle();
        start_i = 1'b0;
        check(busy_o == 1'b1, "R11", 16'(busy_o), 16'd1);
        n = 1;
        seen = 1'b0;
        while (!seen && n < 2000) begin
            if (inject && n == 40) begin
                start_i = 1'b1;
                addr_i  = ~a;
                half_i  = DIV_W'(h + 3);
            end
            cycle();
            start_i = 1'b0;
            n++;
            if (done_o) seen = 1'b1;
        end
        check(n == 60 * eh + 1, inject ? "R10" : "R9", 16'(n), 16'(60 * eh + 1));
        for (int i = 0; i < 3; i++) cycle();
    endtask

    // serial device responder
    int          ncmd = 0;
    int          nrd  = 0;
    logic [10:0] shreg = '0;
    logic        sk_prev = 1'b1;
    logic        cs_prev = 1'b0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (!rst_n) begin
            din_i   <= 1'b0;
            ncmd    = 0;
            nrd     = 0;
            sk_prev = 1'b1;
            cs_prev = 1'b0;
        end else begin
            if (cs_o && !cs_prev) begin
                ncmd  = 0;
                nrd   = 0;
                shreg = '0;
            end
            if (cs_o && sk_o && !sk_prev && ncmd < 11 && (ncmd > 0 || dout_o)) begin
                shreg = {shreg[9:0], dout_o};
                ncmd++;
            end
            if (cs_o && !sk_o && sk_prev && ncmd == 11 && nrd < 16) begin
                w = memval(int'(cur_addr));
                din_i <= w[15 - nrd];
                nrd++;
            end
            if (!cs_o && cs_prev) begin
                check(shreg == {3'b110, 8'(cur_addr)}, "R3", 16'(shreg),
                      16'({3'b110, 8'(cur_addr)}));
            end
            sk_prev = sk_o;
            cs_prev = cs_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++;
            $display("FAIL R9 watchdog expired got %0d exp below %0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset levels
        for (int i = 0; i < 4; i++) cycle();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cycle();
        run_xfer(7'd0, 1, 1'b0);
        run_xfer(7'd127, 2, 1'b0);
        run_xfer(7'h55, 0, 1'b0);   // R9: zero half-period acts as one
        run_xfer(7'h2A, 3, 1'b1);   // R10: start during busy ignored
        run_xfer(7'h3C, 5, 1'b0);
        for (int i = 0; i < 5; i++) cycle();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule